// File: doc/BRIEF.md
# Memory Fill-and-Readback Integrity Tester

This block checks a memory bank in two back-to-back passes. After a start pulse it writes a constant pattern into every location of a test region, one write per cycle, in ascending address order, the way a FIFO fills. When the region is full it issues one read per cycle over the same addresses. It then checks each returned word against the constant.

The memory answers reads through a plain request/valid port with a fixed read latency of 16 cycles. The block tracks every read in flight, so it knows the exact cycle in which each word must come back. Read data that arrives early, late or without a matching read raises a latency flag of its own. This flag is separate from the data-mismatch status.

At the end of a run the block pulses a done flag and holds its results until the next start. The results are a sticky mismatch flag, a saturating mismatch count and the address of the first word that failed.

Top module: `mem_readback_tester`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `lat_err_o` and `mem_req_o` are 0, and `err_cnt_o` and `first_err_addr_o` are 0.
- R2: A 1 on `start_i` while `busy_o` is 0 clears `err_o`, `lat_err_o`, `err_cnt_o` and `first_err_addr_o`, and starts the fill pass in the next cycle. A 1 on `start_i` while `busy_o` is 1 is ignored: it changes neither the run length nor the results.
- R3: The fill pass asserts `mem_req_o` with `mem_we_o`=1 for DEPTH consecutive cycles. The addresses run 0, 1, …, DEPTH-1. `mem_wdata_o` carries byte 0x1E in every byte lane (DATA_W is a multiple of 8). No read is issued before the last write.
- R4: The read pass follows the last write at once. It asserts `mem_req_o` with `mem_we_o`=0 for DEPTH consecutive cycles, at addresses 0 to DEPTH-1 in ascending order.
- R5: A read issued in cycle c is expected with `mem_rvalid_i`=1 in cycle c+16. If all returned words equal the fill pattern, `err_o`=0 and `err_cnt_o`=0 at the end of the run.
- R6: While busy, `lat_err_o` is set if `mem_rvalid_i` is 1 in a cycle where no read is due, or is 0 in a cycle where a read is due. The flag is sticky until the next accepted start. A read that comes back at the wrong time is not compared.
- R7: A word that returns in its due cycle and differs from the pattern sets `err_o`, which is sticky. `first_err_addr_o` takes the address of the first such word and holds it for the rest of the run.
- R8: `err_cnt_o` counts mismatching words and stops at 2^CNT_W-1 without wrapping.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last due read slot. That is 2·DEPTH+17 cycles after the cycle in which the start was accepted. `busy_o` falls in that same cycle, and all results are final by then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only when idle |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write (1) or a read (0) |
| mem_addr_o | output | AW | Request address, AW = clog2(DEPTH) |
| mem_wdata_o | output | DATA_W | Write data (fill pattern) |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DATA_W | Read data |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Sticky data-mismatch flag |
| lat_err_o | output | 1 | Sticky read-latency violation flag |
| err_cnt_o | output | CNT_W | Saturating mismatch count |
| first_err_addr_o | output | AW | Address of the first mismatch |

## Verification
Each kind of internal fault shows up at the ports in its own way:
- **Address counter off by one:** the write or read address order breaks on the bus within a cycle. If it hits the address of an injected corruption, `first_err_addr_o` reports the wrong location by the end of the run.
- **Latency pipe one stage too short or too long:** every read falls in the wrong slot. `lat_err_o` rises in the first due cycle, and the `done_o` cycle moves by one.
- **Counter or capture logic faults:** a wrapping counter or a first-address register that keeps updating can only be seen through the final results after `done_o`. Runs with corruption at address 0, corruption only at the last address, and every address corrupted expose each of these faults within one run.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_READ  = 2'd2,
    ST_DRAIN = 2'd3
  } mrt_state_e;

  localparam logic [7:0] FILL_BYTE = 8'h1E;
endpackage

// File: rtl/mrt_sequencer.sv
module mrt_sequencer
  import mrt_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          drain_done_i,
  output logic          clear_o,
  output logic          busy_o,
  output logic          req_o,
  output logic          we_o,
  output logic          issue_o,
  output logic          last_o,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  mrt_state_e    state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          at_last;

  assign at_last = (addr_q == LAST_ADDR);

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_FILL;
          addr_d  = '0;
        end
      end
      ST_FILL: begin
        if (at_last) begin
          state_d = ST_READ;
          addr_d  = '0;
        end else begin
          addr_d = addr_q + 1'b1;
        end
      end
      ST_READ: begin
        if (at_last) state_d = ST_DRAIN;
        else         addr_d  = addr_q + 1'b1;
      end
      ST_DRAIN: begin
        if (drain_done_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
    end
  end

  assign clear_o = (state_q == ST_IDLE) && start_i;
  assign busy_o  = (state_q != ST_IDLE);
  assign req_o   = (state_q == ST_FILL) || (state_q == ST_READ);
  assign we_o    = (state_q == ST_FILL);
  assign issue_o = (state_q == ST_READ);
  assign last_o  = (state_q == ST_READ) && at_last;
  assign addr_o  = addr_q;
endmodule

// File: rtl/mrt_latency_pipe.sv
module mrt_latency_pipe #(
  parameter int LAT = 16,
  parameter int AW  = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          last_i,
  input  logic [AW-1:0] addr_i,
  output logic          due_o,
  output logic          due_last_o,
  output logic [AW-1:0] due_addr_o
);
  logic [LAT-1:0] vld_q;
  logic [LAT-1:0] lst_q;
  logic [AW-1:0]  adr_q [LAT];

  // Stage k holds a read issued k+1 cycles ago; the tail is due now.
  for (genvar g = 0; g < LAT; g++) begin : g_stage
    logic          v_in, l_in;
    logic [AW-1:0] a_in;
    if (g == 0) begin : g_head
      assign v_in = push_i;
      assign l_in = last_i;
      assign a_in = addr_i;
    end else begin : g_body
      assign v_in = vld_q[g-1];
      assign l_in = lst_q[g-1];
      assign a_in = adr_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        lst_q[g] <= 1'b0;
        adr_q[g] <= '0;
      end else begin
        vld_q[g] <= v_in;
        lst_q[g] <= v_in && l_in;
        adr_q[g] <= a_in;
      end
    end
  end

  assign due_o      = vld_q[LAT-1];
  assign due_last_o = lst_q[LAT-1];
  assign due_addr_o = adr_q[LAT-1];
endmodule

// File: rtl/mrt_result_tracker.sv
module mrt_result_tracker
  import mrt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AW     = 5,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              active_i,
  input  logic              due_i,
  input  logic              due_last_i,
  input  logic [AW-1:0]     due_addr_i,
  input  logic              rvalid_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic              lat_err_o,
  output logic [CNT_W-1:0]  err_cnt_o,
  output logic [AW-1:0]     first_err_addr_o
);
  localparam logic [DATA_W-1:0] PATTERN = {(DATA_W/8){FILL_BYTE}};
  localparam logic [CNT_W-1:0]  CNT_MAX = '1;

  logic             mismatch, lat_viol;
  logic             err_q, lat_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [AW-1:0]    first_q;

  assign mismatch = due_i && rvalid_i && (rdata_i != PATTERN);
  assign lat_viol = active_i && (due_i != rvalid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= 1'b0;
      lat_q   <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      first_q <= '0;
    end else if (clear_i) begin
      err_q   <= 1'b0;
      lat_q   <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      first_q <= '0;
    end else begin
      done_q <= due_i && due_last_i;
      if (lat_viol) lat_q <= 1'b1;
      if (mismatch) begin
        err_q <= 1'b1;
        if (!err_q) first_q <= due_addr_i;
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign done_o           = done_q;
  assign err_o            = err_q;
  assign lat_err_o        = lat_q;
  assign err_cnt_o        = cnt_q;
  assign first_err_addr_o = first_q;
endmodule

// File: rtl/mem_readback_tester.sv
module mem_readback_tester
  import mrt_pkg::*;
#(
  parameter  int DEPTH    = 32,
  parameter  int DATA_W   = 32,
  parameter  int READ_LAT = 16,
  parameter  int CNT_W    = 4,
  localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              lat_err_o,
  output logic [CNT_W-1:0]  err_cnt_o,
  output logic [AW-1:0]     first_err_addr_o
);
  logic          clear, busy, issue, last_rd;
  logic          due, due_last;
  logic [AW-1:0] due_addr;

  mrt_sequencer #(.DEPTH(DEPTH), .AW(AW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .drain_done_i(due && due_last),
    .clear_o     (clear),
    .busy_o      (busy),
    .req_o       (mem_req_o),
    .we_o        (mem_we_o),
    .issue_o     (issue),
    .last_o      (last_rd),
    .addr_o      (mem_addr_o)
  );

  mrt_latency_pipe #(.LAT(READ_LAT), .AW(AW)) u_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (issue),
    .last_i    (last_rd),
    .addr_i    (mem_addr_o),
    .due_o     (due),
    .due_last_o(due_last),
    .due_addr_o(due_addr)
  );

  mrt_result_tracker #(.DATA_W(DATA_W), .AW(AW), .CNT_W(CNT_W)) u_res (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .clear_i         (clear),
    .active_i        (busy),
    .due_i           (due),
    .due_last_i      (due_last),
    .due_addr_i      (due_addr),
    .rvalid_i        (mem_rvalid_i),
    .rdata_i         (mem_rdata_i),
    .done_o          (done_o),
    .err_o           (err_o),
    .lat_err_o       (lat_err_o),
    .err_cnt_o       (err_cnt_o),
    .first_err_addr_o(first_err_addr_o)
  );

  assign mem_wdata_o = {(DATA_W/8){FILL_BYTE}};
  assign busy_o      = busy;
endmodule

// File: rtl/mrt_sva.sv
module mrt_sva #(
  parameter int DATA_W = 32,
  parameter int AW     = 5,
  parameter int CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [AW-1:0]     mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              lat_err_o,
  input logic [CNT_W-1:0]  err_cnt_o,
  input logic [AW-1:0]     first_err_addr_o
);
  localparam logic [DATA_W-1:0] PAT = {(DATA_W/8){8'h1E}};
  localparam logic [CNT_W-1:0]  MAXC = '1;

  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o) else $error("idle request"); // R1
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !err_o && !lat_err_o && err_cnt_o == '0)) else $error("start"); // R2
  AST_FILL_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_wdata_o == PAT)) else $error("pattern"); // R3
  AST_READ_ASCENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && $past(mem_req_o && !mem_we_o)) |->
      (mem_addr_o == AW'($past(mem_addr_o) + 1'b1))) else $error("read order"); // R4
  AST_LAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_err_o && !start_i) |=> lat_err_o) else $error("lat sticky"); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> err_o) else $error("err sticky"); // R7
  AST_FIRST_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> $stable(first_err_addr_o)) else $error("first addr"); // R7
  AST_CNT_IMPLIES_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o != '0) |-> err_o) else $error("count vs flag"); // R7
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o == MAXC && !start_i) |=> (err_cnt_o == MAXC)) else $error("wrap"); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done width"); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o) else $error("done busy"); // R9
endmodule

bind mem_readback_tester mrt_sva #(.DATA_W(DATA_W), .AW(AW), .CNT_W(CNT_W)) i_sva (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .start_i         (start_i),
  .mem_req_o       (mem_req_o),
  .mem_we_o        (mem_we_o),
  .mem_addr_o      (mem_addr_o),
  .mem_wdata_o     (mem_wdata_o),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .err_o           (err_o),
  .lat_err_o       (lat_err_o),
  .err_cnt_o       (err_cnt_o),
  .first_err_addr_o(first_err_addr_o)
);

// File: tb/test_mem_readback_tester.sv
module test_mem_readback_tester;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 32;
  localparam int DATA_W = 32;
  localparam int LAT    = 16;
  localparam int CNT_W  = 4;
  localparam int AW     = $clog2(DEPTH);
  localparam logic [DATA_W-1:0] PAT = {(DATA_W/8){8'h1E}};
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int RUN_LEN = 2 * DEPTH + LAT + 1;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic mem_req_o, mem_we_o, mem_rvalid_i;
  logic [AW-1:0] mem_addr_o, first_err_addr_o;
  logic [DATA_W-1:0] mem_wdata_o, mem_rdata_i;
  logic busy_o, done_o, err_o, lat_err_o;
  logic [CNT_W-1:0] err_cnt_o;

  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mem_readback_tester #(.DEPTH(DEPTH), .DATA_W(DATA_W), .READ_LAT(LAT), .CNT_W(CNT_W)) i_mem_readback_tester (
    .clk_i, .rst_ni, .start_i, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rvalid_i, .mem_rdata_i, .busy_o, .done_o, .err_o, .lat_err_o,
    .err_cnt_o, .first_err_addr_o
  );

  // Behavioural memory with fault injection
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] corrupt [DEPTH];
  logic              slip_en = 1'b0;
  logic [AW-1:0]     slip_addr = '0;
  logic [LAT-1:0]    pv;
  logic [AW-1:0]     pa [LAT];
  logic              dly_v;
  logic [AW-1:0]     dly_a;
  logic              tail_slip;

  int wr_cnt = 0, wr_bad = 0, rd_cnt = 0, rd_bad = 0;

  assign tail_slip    = pv[LAT-1] && slip_en && (pa[LAT-1] == slip_addr);
  assign mem_rvalid_i = (pv[LAT-1] && !tail_slip) || dly_v;
  assign mem_rdata_i  = (pv[LAT-1] && !tail_slip) ? (mem[pa[LAT-1]] ^ corrupt[pa[LAT-1]])
                                                  : (mem[dly_a] ^ corrupt[dly_a]);

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv    <= '0;
      dly_v <= 1'b0;
      dly_a <= '0;
    end else begin
      pv    <= {pv[LAT-2:0], mem_req_o && !mem_we_o};
      pa[0] <= mem_addr_o;
      for (int k = 1; k < LAT; k++) pa[k] <= pa[k-1];
      dly_v <= tail_slip;
      dly_a <= pa[LAT-1];
      if (mem_req_o && mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    end
  end

  // Bus-order monitor (R3, R4)
  always @(posedge clk_i) begin
    if (rst_ni && mem_req_o) begin
      if (mem_we_o) begin
        if (int'(mem_addr_o) != wr_cnt || mem_wdata_o != PAT || rd_cnt != 0) wr_bad++;
        wr_cnt++;
      end else begin
        if (int'(mem_addr_o) != rd_cnt || wr_cnt != DEPTH) rd_bad++;
        rd_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_count();
    int c = 0;
    for (int a = 0; a < DEPTH; a++) if (corrupt[a] != '0) c++;
    return (c > CNT_MAX) ? CNT_MAX : c;
  endfunction

  function automatic int exp_first();
    for (int a = 0; a < DEPTH; a++) if (corrupt[a] != '0) return a;
    return 0;
  endfunction

  task automatic clear_faults();
    for (int a = 0; a < DEPTH; a++) corrupt[a] = '0;
    slip_en = 1'b0;
  endtask

  // One full run; mid_start pulses start while busy (must be ignored, R2)
  task automatic run_test(input string tag, input bit exp_lat, input bit mid_start);
    int n;
    int ec, ef;
    ec = exp_count();
    ef = exp_first();
    @(negedge clk_i);
    wr_cnt = 0; wr_bad = 0; rd_cnt = 0; rd_bad = 0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    n = 1;
    chk(busy_o && !err_o && !lat_err_o && err_cnt_o == 0, {"R2 clear ", tag}, {busy_o, err_o, lat_err_o}, 3'b100);
    while (!done_o) begin
      @(negedge clk_i);
      n++;
      start_i = mid_start && (n == 40);
    end
    start_i = 1'b0;
    chk(n == RUN_LEN, {"R9 done cycle ", tag}, n, RUN_LEN);
    chk(!busy_o, {"R9 busy low at done ", tag}, busy_o, 0);
    chk(wr_cnt == DEPTH && wr_bad == 0, {"R3 fill order/data ", tag}, wr_bad, 0);
    chk(rd_cnt == DEPTH && rd_bad == 0, {"R4 read order ", tag}, rd_bad, 0);
    chk(lat_err_o == exp_lat, {"R6 latency flag ", tag}, lat_err_o, exp_lat);
    chk(int'(err_cnt_o) == ec, {"R8 count ", tag}, err_cnt_o, ec);
    chk(err_o == (ec != 0), {"R7 err flag ", tag}, err_o, ec != 0);
    if (ec != 0) chk(int'(first_err_addr_o) == ef, {"R7 first addr ", tag}, first_err_addr_o, ef);
    @(negedge clk_i);
    chk(!done_o, {"R9 done one cycle ", tag}, done_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd8675309));
    clear_faults();
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !err_o && !lat_err_o && !mem_req_o, "R1 reset flags", 0, 0);
    chk(err_cnt_o == 0 && first_err_addr_o == 0, "R1 reset values", err_cnt_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !mem_req_o, "R1 idle after reset", busy_o, 0);

    run_test("R5 clean", 1'b0, 1'b0);

    clear_faults();
    corrupt[0] = 32'h0000_0001;
    corrupt[DEPTH-1] = 32'h8000_0000;
    run_test("R7 ends", 1'b0, 1'b0);

    clear_faults();
    corrupt[DEPTH-1] = 32'h00FF_0000;
    run_test("R7 last only", 1'b0, 1'b0);

    clear_faults();
    for (int a = 0; a < DEPTH; a++) corrupt[a] = DATA_W'(a + 1);
    run_test("R8 all bad", 1'b0, 1'b0);

    clear_faults();
    slip_en = 1'b1;
    slip_addr = AW'(DEPTH / 2);
    run_test("R6 slip", 1'b1, 1'b0);

    clear_faults();
    run_test("R2 after slip", 1'b0, 1'b0);

    clear_faults();
    corrupt[5] = 32'h0000_0100;
    corrupt[9] = 32'h0001_0000;
    run_test("R2 mid start", 1'b0, 1'b1);

    for (int r = 0; r < 6; r++) begin
      clear_faults();
      for (int a = 0; a < DEPTH; a++)
        if ($urandom_range(0, 3) == 0) corrupt[a] = DATA_W'($urandom) | 1;
      run_test($sformatf("R7 random %0d", r), 1'b0, 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule